// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit sits in the decode stage of a five-stage in-order 32-bit pipeline. It decides conditional branches there rather than later in the pipe. The two branch kinds are "taken when operands match" and "taken when operands differ". In the same cycle it compares the two register operands of the branch and forms the branch target address. When the branch is taken, it raises a redirect toward fetch and a flush that turns the single already-fetched instruction into a bubble. A wrong guess therefore costs one cycle. A not-taken branch lets the sequentially fetched instruction flow on with no penalty.

Resolving this early has a cost. A value that is still being produced can feed the comparison:

- An ALU or load instruction in execute that writes one of the branch's source registers holds the branch for one cycle.
- A load in the memory stage that writes one of those registers holds it for one more cycle, because load data only exists after that stage.

While the branch is held, the stall output freezes the PC and the IF/ID register and places a bubble in ID/EX. The stall also suppresses any redirect or flush until the operands are good. Register 0 never causes a hold.

Two free-running counters expose the number of resolved taken branches and the number of stall cycles, so the penalties can be measured. All pins are plain control and status signals. No data stream crosses the block edge, so there is no valid/ready handshake or back-pressure.

Top module: `branch_resolve_unit`

## Requirements
- R1: With branch kind 2'b01 (match), the branch is taken exactly when operand A equals operand B.
- R2: With branch kind 2'b10 (differ), the branch is taken exactly when operand A differs from operand B.
- R3: The redirect address equals the branch's PC+4 plus the 16-bit offset sign-extended to 32 bits and shifted left by two, including negative offsets.
- R4: A taken, non-stalled branch raises both redirect and flush in the same cycle it is presented.
- R5: A not-taken branch raises neither redirect nor flush.
- R6: An execute-stage instruction with its write enable set, whose destination is a nonzero source register of the branch, raises stall. This applies whether the instruction is an ALU operation or a load.
- R7: A memory-stage load with write enable set, whose destination is a nonzero source register of the branch, raises stall. A memory-stage non-load does not raise stall.
- R8: A destination of register 0 never raises stall.
- R9: While stall is high, redirect and flush stay low whatever the operands.
- R10: The taken counter resets to 0 and increments by one on each clock edge where a taken branch resolves with no stall.
- R11: The stall counter resets to 0 and increments by one on each clock edge where stall is high.
- R12: Branch kinds 2'b00 and 2'b11 mean no branch: stall, redirect and flush stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_kind | input | 2 | Branch kind: 00 none, 01 match, 10 differ, 11 none |
| dec_pc_next | input | 32 | PC+4 of the branch |
| dec_offset | input | 16 | Word offset from the instruction |
| dec_src_a | input | 5 | Register index of operand A |
| dec_src_b | input | 5 | Register index of operand B |
| dec_opnd_a | input | 32 | Operand A value (after forwarding) |
| dec_opnd_b | input | 32 | Operand B value (after forwarding) |
| exe_wr_en | input | 1 | Execute-stage instruction writes a register |
| exe_dst | input | 5 | Execute-stage destination register |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_dst | input | 5 | Memory-stage destination register |
| redirect | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | Branch target address |
| flush_fetch | output | 1 | Turn the IF/ID instruction into a bubble |
| stall | output | 1 | Freeze PC and IF/ID, bubble into ID/EX |
| taken_count | output | 16 | Resolved taken branches |
| stall_count | output | 16 | Stall cycles |

## Verification
Random vectors draw register indices from a small pool that includes register 0, so hazard matches, zero-register matches and misses all occur often. Operand values are equal about half the time, which separates the match kind from the differ kind on identical data. Directed cases cover four things: a negative and a positive offset, which separate correct sign extension from zero extension; a load walking from execute to memory, which shows the two-cycle hold against the one-cycle hold for an ALU producer; a memory-stage non-load, which must not hold; and the two no-branch encodings.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    BR_NONE  = 2'b00,
    BR_MATCH = 2'b01,
    BR_DIFF  = 2'b10,
    BR_RSVD  = 2'b11
  } br_kind_t;
endpackage

// File: rtl/bru_compare.sv
module bru_compare #(
  parameter int XLEN = 32
) (
  input  bru_pkg::br_kind_t kind,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  output logic              is_branch,
  output logic              cond_true
);
  logic same;
  assign same = (opnd_a == opnd_b);

  always_comb begin
    is_branch = 1'b0;
    cond_true = 1'b0;
    unique case (kind)
      bru_pkg::BR_MATCH: begin is_branch = 1'b1; cond_true = same;  end
      bru_pkg::BR_DIFF:  begin is_branch = 1'b1; cond_true = !same; end
      default:           begin is_branch = 1'b0; cond_true = 1'b0;  end
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  pc_next,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);
  localparam int EXT_W = XLEN - OFF_W - 2;
  logic [XLEN-1:0] disp;
  assign disp   = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign target = pc_next + disp;
endmodule

// File: rtl/bru_hazard.sv
module bru_hazard #(
  parameter int REG_W = 5
) (
  input  logic             active,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             exe_wr_en,
  input  logic [REG_W-1:0] exe_dst,
  input  logic             mem_wr_en,
  input  logic             mem_is_load,
  input  logic [REG_W-1:0] mem_dst,
  output logic             hold
);
  localparam int NSRC = 2;
  logic [REG_W-1:0] srcs [NSRC];
  logic [NSRC-1:0]  hit;

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic nonzero, exe_hit, mem_hit;
    assign nonzero = (srcs[s] != '0);
    assign exe_hit = exe_wr_en && (exe_dst == srcs[s]);
    assign mem_hit = mem_wr_en && mem_is_load && (mem_dst == srcs[s]);
    assign hit[s]  = nonzero && (exe_hit || mem_hit);
  end

  assign hold = active && (|hit);
endmodule

// File: rtl/bru_counters.sv
module bru_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             taken_ev,
  input  logic             stall_ev,
  output logic [CNT_W-1:0] taken_cnt,
  output logic [CNT_W-1:0] stall_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_cnt <= '0;
      stall_cnt <= '0;
    end else begin
      if (taken_ev) taken_cnt <= taken_cnt + 1'b1;
      if (stall_ev) stall_cnt <= stall_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int REG_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       dec_kind,
  input  logic [XLEN-1:0]  dec_pc_next,
  input  logic [OFF_W-1:0] dec_offset,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [XLEN-1:0]  dec_opnd_a,
  input  logic [XLEN-1:0]  dec_opnd_b,
  input  logic             exe_wr_en,
  input  logic [REG_W-1:0] exe_dst,
  input  logic             mem_wr_en,
  input  logic             mem_is_load,
  input  logic [REG_W-1:0] mem_dst,
  output logic             redirect,
  output logic [XLEN-1:0]  redirect_pc,
  output logic             flush_fetch,
  output logic             stall,
  output logic [CNT_W-1:0] taken_count,
  output logic [CNT_W-1:0] stall_count
);
  bru_pkg::br_kind_t kind;
  logic is_branch, cond_true, hold, resolve_taken;

  assign kind = bru_pkg::br_kind_t'(dec_kind);

  bru_compare #(.XLEN(XLEN)) u_cmp (
    .kind(kind), .opnd_a(dec_opnd_a), .opnd_b(dec_opnd_b),
    .is_branch(is_branch), .cond_true(cond_true)
  );

  bru_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc_next(dec_pc_next), .offset(dec_offset), .target(redirect_pc)
  );

  bru_hazard #(.REG_W(REG_W)) u_haz (
    .active(is_branch), .src_a(dec_src_a), .src_b(dec_src_b),
    .exe_wr_en(exe_wr_en), .exe_dst(exe_dst),
    .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load), .mem_dst(mem_dst),
    .hold(hold)
  );

  // Stall wins: no decision until operands are final.
  assign resolve_taken = is_branch && cond_true && !hold;
  assign redirect      = resolve_taken;
  assign flush_fetch   = resolve_taken;
  assign stall         = hold;

  bru_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .taken_ev(resolve_taken), .stall_ev(hold),
    .taken_cnt(taken_count), .stall_cnt(stall_count)
  );
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
  parameter int CNT_W = 16,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       dec_kind,
  input logic             exe_wr_en,
  input logic [REG_W-1:0] exe_dst,
  input logic             mem_wr_en,
  input logic [REG_W-1:0] mem_dst,
  input logic             redirect,
  input logic             flush_fetch,
  input logic             stall,
  input logic [CNT_W-1:0] taken_count,
  input logic [CNT_W-1:0] stall_count
);
  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!redirect && !flush_fetch));

  assert_no_branch_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_kind == 2'b00 || dec_kind == 2'b11) |-> (!stall && !redirect && !flush_fetch));

  assert_zero_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!exe_wr_en || exe_dst == '0) && (!mem_wr_en || mem_dst == '0)) |-> !stall);

  assert_taken_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (taken_count == $past(taken_count) + 1'b1));

  assert_stall_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (stall_count == $past(stall_count)));

  assert_flush_pairs_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fetch |-> redirect);
endmodule

bind branch_resolve_unit bru_checker #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_kind(dec_kind),
  .exe_wr_en(exe_wr_en), .exe_dst(exe_dst),
  .mem_wr_en(mem_wr_en), .mem_dst(mem_dst),
  .redirect(redirect), .flush_fetch(flush_fetch), .stall(stall),
  .taken_count(taken_count), .stall_count(stall_count)
);

// File: tb/branch_resolve_unit_tb.sv
module branch_resolve_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  dec_kind;
  logic [31:0] dec_pc_next, dec_opnd_a, dec_opnd_b;
  logic [15:0] dec_offset;
  logic [4:0]  dec_src_a, dec_src_b, exe_dst, mem_dst;
  logic        exe_wr_en, mem_wr_en, mem_is_load;
  logic        redirect, flush_fetch, stall;
  logic [31:0] redirect_pc;
  logic [15:0] taken_count, stall_count;

  int errors = 0, checks = 0;
  int exp_taken = 0, exp_stall = 0;

  always #10 clk = ~clk;  // 50 MHz

  branch_resolve_unit u_dut (
    .clk(clk), .rst_n(rst_n), .dec_kind(dec_kind), .dec_pc_next(dec_pc_next),
    .dec_offset(dec_offset), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_opnd_a(dec_opnd_a), .dec_opnd_b(dec_opnd_b),
    .exe_wr_en(exe_wr_en), .exe_dst(exe_dst),
    .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load), .mem_dst(mem_dst),
    .redirect(redirect), .redirect_pc(redirect_pc), .flush_fetch(flush_fetch),
    .stall(stall), .taken_count(taken_count), .stall_count(stall_count)
  );

  function automatic logic f_branch(input logic [1:0] k);
    return (k == 2'b01) || (k == 2'b10);
  endfunction

  function automatic logic f_hit(input logic [4:0] s);
    return (s != 5'd0) && ((exe_wr_en && exe_dst == s) ||
                           (mem_wr_en && mem_is_load && mem_dst == s));
  endfunction

  function automatic logic f_stall();
    return f_branch(dec_kind) && (f_hit(dec_src_a) || f_hit(dec_src_b));
  endfunction

  function automatic logic f_taken();
    logic c;
    c = (dec_kind == 2'b01) ? (dec_opnd_a == dec_opnd_b) : (dec_opnd_a != dec_opnd_b);
    return f_branch(dec_kind) && c && !f_stall();
  endfunction

  function automatic logic [31:0] f_target();
    return dec_pc_next + {{14{dec_offset[15]}}, dec_offset, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_kind = 2'b00; dec_pc_next = 32'h100; dec_offset = 16'h0;
    dec_src_a = 5'd0; dec_src_b = 5'd0; dec_opnd_a = 0; dec_opnd_b = 0;
    exe_wr_en = 0; exe_dst = 0; mem_wr_en = 0; mem_is_load = 0; mem_dst = 0;
  endtask

  // Inputs already set at a negedge; check outputs, then step one clock.
  task automatic apply(input string req);
    logic es, et;
    #2;
    es = f_stall(); et = f_taken();
    check({req, " stall"}, {31'd0, stall}, {31'd0, es});
    check({req, " redirect"}, {31'd0, redirect}, {31'd0, et});
    check({req, " flush"}, {31'd0, flush_fetch}, {31'd0, et});
    if (et) check({req, " R3 target"}, redirect_pc, f_target());
    if (es) exp_stall++;
    if (et) exp_taken++;
    @(negedge clk);
    check("R10 taken count", {16'd0, taken_count}, exp_taken);
    check("R11 stall count", {16'd0, stall_count}, exp_stall);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R10 reset taken", {16'd0, taken_count}, 0);
    check("R11 reset stall", {16'd0, stall_count}, 0);
    rst_n = 1;

    // R1 match equal -> taken, negative offset for R3
    dec_kind = 2'b01; dec_opnd_a = 32'h55; dec_opnd_b = 32'h55;
    dec_pc_next = 32'h0000_1000; dec_offset = 16'hFFFC;
    apply("R1 R4 match-equal");
    #2 check("R3 negative offset", redirect_pc, 32'h0000_1000 + 32'h0000_1000 - 32'h1010);
    // R5 match unequal -> not taken
    dec_opnd_b = 32'h56; apply("R5 match-unequal");
    // R2 differ
    dec_kind = 2'b10; dec_offset = 16'h0010; apply("R2 differ-unequal");
    #2 check("R3 positive offset", redirect_pc, 32'h0000_1040);
    dec_opnd_b = 32'h55; apply("R2 R5 differ-equal");
    // R12 no-branch encodings with a live hazard and differing operands
    dec_opnd_b = 32'h1; dec_src_a = 5'd3; exe_wr_en = 1; exe_dst = 5'd3;
    dec_kind = 2'b00; apply("R12 kind00");
    dec_kind = 2'b11; apply("R12 kind11");
    // R6 ALU in execute on operand B
    dec_kind = 2'b10; dec_src_a = 5'd0; dec_src_b = 5'd7; exe_dst = 5'd7;
    apply("R6 R9 exe hit");
    // R8 register zero destinations
    dec_src_a = 5'd0; dec_src_b = 5'd0; exe_dst = 5'd0;
    mem_wr_en = 1; mem_is_load = 1; mem_dst = 5'd0; apply("R8 zero reg");
    // R7 load: execute then memory stage, then resolve
    dec_kind = 2'b01; dec_opnd_a = 32'h9; dec_opnd_b = 32'h9; dec_src_a = 5'd4;
    exe_wr_en = 1; exe_dst = 5'd4; mem_wr_en = 0; mem_is_load = 0;
    apply("R7 load in exe");
    exe_wr_en = 0; mem_wr_en = 1; mem_is_load = 1; mem_dst = 5'd4;
    apply("R7 load in mem");
    mem_is_load = 0; apply("R7 mem non-load no stall");
    mem_wr_en = 0; apply("R4 resolve after hold");

    for (int i = 0; i < 400; i++) begin
      dec_kind    = 2'($urandom);
      dec_pc_next = $urandom & 32'hFFFF_FFFC;
      dec_offset  = 16'($urandom);
      dec_src_a   = 5'($urandom % 4);
      dec_src_b   = 5'($urandom % 4);
      dec_opnd_a  = $urandom % 3;
      dec_opnd_b  = ($urandom % 2 == 0) ? dec_opnd_a : $urandom;
      exe_wr_en   = 1'($urandom);
      exe_dst     = 5'($urandom % 5);
      mem_wr_en   = 1'($urandom);
      mem_is_load = 1'($urandom);
      mem_dst     = 5'($urandom % 5);
      apply("R1 R2 R6 R7 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule